// File: doc/BRIEF.md
# Pause-Width Keyed Frame Transmitter

This block sends a short frame from a reader to a tag by switching a carrier-enable output. Every bit begins with a carrier-off gap of fixed length, and the carrier then stays on. The total time of the bit, gap included, carries the value: a long bit is a one and a short bit is a zero. Before a bit is encoded, its data value is XORed with one keystream bit taken from an external port. The block requests the next keystream bit with a one-cycle advance pulse once per bit.

All durations are counted in tick-enable cycles, not in clock cycles. The surrounding logic supplies `tick_i` from a divided clock, and gaps between ticks only stretch the waveform. A frame holds 1 to 32 bits, taken from a data word least significant bit first. One more carrier-off gap after the last bit closes the frame. The carrier then returns to on and a done pulse is given. The internal tick count starts from zero at that point, so the tag reply can be timed from it.

Top module: `pwk_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `carrier_o` is 1 and both `ks_adv_o` and `done_o` are 0.
- R2: Every bit starts with `carrier_o` at 0 for exactly PAUSE_T ticks (default 30).
- R3: The value sent for bit i is `data_i[i]` XOR the value on `ks_bit_i` when that bit's pause begins. Bits go out least significant first, bit 0 first.
- R4: A sent 1 lasts ONE_T ticks in total (default 150, so 120 ticks carrier on). A sent 0 lasts ZERO_T ticks in total (default 90, so 60 ticks carrier on).
- R5: `ks_adv_o` pulses for exactly one cycle per bit, during the carrier-on part of that bit, so a frame of N bits gives exactly N pulses.
- R6: After the last bit, `carrier_o` goes to 0 for one further PAUSE_T ticks and then returns to 1. `done_o` is 1 for exactly one cycle, in the first cycle with the carrier back on.
- R7: `nbits_i` (6 bits) gives the frame length, 1 to 32. A start with `nbits_i` of 0 or above 32 is ignored: the carrier stays on and no done pulse follows.
- R8: A `start_i` that arrives while a frame is in progress is ignored. The running frame completes unchanged and only one done pulse is given.
- R9: A tick is counted only in a cycle where `tick_i` is 1. Cycles without a tick leave the count, and so the tick-measured durations, unchanged.
- R10: The tick count is cleared at the end of the frame. A new frame started right after `done_o` has a full-length first pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| data_i | input | 32 | Frame data, bit 0 sent first |
| nbits_i | input | 6 | Number of bits to send, 1 to 32 |
| ks_bit_i | input | 1 | Current keystream bit |
| tick_i | input | 1 | Timing tick enable |
| carrier_o | output | 1 | Carrier enable, 1 = on |
| ks_adv_o | output | 1 | Keystream advance pulse |
| done_o | output | 1 | Frame complete pulse |

## Verification
The bench builds the block with its default timing of 30, 150 and 90 ticks and a 32-bit data word. These values bring the longest frame and the 32-bit limit of the count field within reach. The bench drives `tick_i` every cycle and also every second and third cycle, which shows that durations follow ticks and not clock cycles. Keystream words that flip some data bits and not others show that whitening applies to each bit.

// File: rtl/pwk_pkg.sv
package pwk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PAUSE = 2'd1,
    ST_MARK  = 2'd2,
    ST_TAIL  = 2'd3
  } pwk_state_e;

  // Line value of one bit: data whitened by keystream.
  function automatic logic whiten(input logic data_bit, input logic key_bit);
    return data_bit ^ key_bit;
  endfunction

  // Total length of a bit in ticks, pause included.
  function automatic int bit_span(input logic line_bit, input int one_t, input int zero_t);
    return line_bit ? one_t : zero_t;
  endfunction

  // A frame length is legal from 1 up to the data width.
  function automatic logic len_legal(input int len, input int max_len);
    return (len >= 1) && (len <= max_len);
  endfunction

endpackage

// File: rtl/pwk_tick_counter.sv
module pwk_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (tick_i)  cnt_o <= cnt_o + W'(1);
  end

  // A cycle without a tick leaves the count alone (R9)
  p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !tick_i) |=> $stable(cnt_o));

endmodule

// File: rtl/pwk_bit_queue.sv
module pwk_bit_queue #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [LEN_W-1:0]  load_len_i,
  output logic              head_o,
  output logic              last_o
);

  logic [DATA_W-1:0] sreg;
  logic [LEN_W-1:0]  remain;

  // On load, bit 0 is consumed at once by the caller; the queue keeps the rest.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      remain <= '0;
    end else if (load_i) begin
      sreg   <= load_data_i >> 1;
      remain <= load_len_i - LEN_W'(1);
    end else if (pop_i) begin
      sreg   <= sreg >> 1;
      remain <= remain - LEN_W'(1);
    end
  end

  assign head_o = sreg[0];
  assign last_o = (remain == '0);

  // Never pop past the end of the frame (R3)
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !last_o);

endmodule

// File: rtl/pwk_frame_tx.sv
module pwk_frame_tx #(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = $clog2(DATA_W + 1),
  parameter int PAUSE_T = 30,
  parameter int ONE_T   = 150,
  parameter int ZERO_T  = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  nbits_i,
  input  logic              ks_bit_i,
  input  logic              tick_i,
  output logic              carrier_o,
  output logic              ks_adv_o,
  output logic              done_o
);
  import pwk_pkg::*;

  localparam int MAX_T  = (ONE_T > ZERO_T) ? ONE_T : ZERO_T;
  localparam int TCNT_W = $clog2(MAX_T + 1);
  localparam logic [TCNT_W-1:0] PAUSE_LAST = TCNT_W'(PAUSE_T - 1);

  pwk_state_e        fsm;
  logic              line_bit;
  logic              carrier_q, adv_q, done_q;
  logic [TCNT_W-1:0] tick_cnt;
  logic              cnt_clr;
  logic              q_load, q_pop, q_head, q_last;

  // Named internal events
  logic count_ok, accept, pause_end, mark_end, tail_end;
  logic [TCNT_W-1:0] mark_last;

  assign count_ok  = len_legal(int'(nbits_i), DATA_W);
  assign accept    = (fsm == ST_IDLE) && start_i && count_ok;
  assign mark_last = TCNT_W'(bit_span(line_bit, ONE_T, ZERO_T) - 1);
  assign pause_end = (fsm == ST_PAUSE) && tick_i && (tick_cnt == PAUSE_LAST);
  assign mark_end  = (fsm == ST_MARK)  && tick_i && (tick_cnt == mark_last);
  assign tail_end  = (fsm == ST_TAIL)  && tick_i && (tick_cnt == PAUSE_LAST);

  assign q_load  = accept;
  assign q_pop   = mark_end && !q_last;
  assign cnt_clr = (fsm == ST_IDLE) || mark_end || tail_end;

  pwk_tick_counter #(.W(TCNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .tick_i (tick_i),
    .cnt_o  (tick_cnt)
  );

  pwk_bit_queue #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (q_load),
    .pop_i       (q_pop),
    .load_data_i (data_i),
    .load_len_i  (nbits_i),
    .head_o      (q_head),
    .last_o      (q_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm       <= ST_IDLE;
      line_bit  <= 1'b0;
      carrier_q <= 1'b1;
      adv_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      adv_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (fsm)
        ST_IDLE: if (accept) begin
          fsm       <= ST_PAUSE;
          line_bit  <= whiten(data_i[0], ks_bit_i);
          carrier_q <= 1'b0;
        end
        ST_PAUSE: if (pause_end) begin
          fsm       <= ST_MARK;
          carrier_q <= 1'b1;
          adv_q     <= 1'b1;
        end
        ST_MARK: if (mark_end) begin
          carrier_q <= 1'b0;
          if (q_last) begin
            fsm <= ST_TAIL;
          end else begin
            fsm      <= ST_PAUSE;
            line_bit <= whiten(q_head, ks_bit_i);
          end
        end
        ST_TAIL: if (tail_end) begin
          fsm       <= ST_IDLE;
          carrier_q <= 1'b1;
          done_q    <= 1'b1;
        end
        default: fsm <= ST_IDLE;
      endcase
    end
  end

  assign carrier_o = carrier_q;
  assign ks_adv_o  = adv_q;
  assign done_o    = done_q;

  // Each carrier-off gap is timed from a cleared count (R2, R10)
  p_pause_fresh_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carrier_o) |-> (tick_cnt == '0));

  // Count never runs beyond the longest bit (R4)
  p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt < TCNT_W'(MAX_T));

  // Advance only while the carrier is on, one cycle wide (R5)
  p_adv_with_carrier_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv_o |-> carrier_o);
  p_adv_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv_o |=> !ks_adv_o);

  // Done comes with the carrier's return after the closing gap (R6)
  p_done_on_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (carrier_o && $past(!carrier_o)));
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // Illegal lengths leave the block idle (R7)
  p_bad_len_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((fsm == ST_IDLE) && start_i && !count_ok) |=> (carrier_o && fsm == ST_IDLE));

  // Start during a frame does not reload the queue (R8)
  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((fsm != ST_IDLE) && start_i) |-> !q_load);

endmodule

// File: tb/pwk_frame_tx_tb_top.sv
module pwk_frame_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [5:0]  nbits_i = '0;
  logic        ks_bit_i = 1'b0;
  logic        tick_i = 1'b0;
  logic        carrier_o, ks_adv_o, done_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  pwk_frame_tx dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .data_i    (data_i),
    .nbits_i   (nbits_i),
    .ks_bit_i  (ks_bit_i),
    .tick_i    (tick_i),
    .carrier_o (carrier_o),
    .ks_adv_o  (ks_adv_o),
    .done_o    (done_o)
  );

  // Bench's own timing figures, in ticks
  localparam int GAP_T  = 30;
  localparam int HI_ONE = 150 - 30;
  localparam int HI_ZER = 90 - 30;

  localparam int NV = 6;
  localparam logic [31:0] VDATA [NV] = '{32'h0000_0055, 32'hDEAD_BEEF, 32'h0, 32'h1, 32'h0000_FFFF, 32'h0000_3C5A};
  localparam logic [31:0] VKEY  [NV] = '{32'h0, 32'h1234_5678, 32'h0, 32'h1, 32'h0000_0F0F, 32'hFFFF_FFFF};
  localparam int          VLEN  [NV] = '{7, 32, 1, 1, 16, 13};
  localparam int          VGAP  [NV] = '{1, 1, 1, 1, 3, 2};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  // Sends one frame and decodes the carrier waveform by ticks.
  task automatic run_frame(input logic [31:0] d, input logic [31:0] k,
                           input int len, input int gap, input bit poke);
    int nlow = 0, nhigh = 0, run = 0, adv = 0, badlow = 0, badhigh = 0, cyc = 0, ndone = 0;
    logic prev = 1'b0;
    logic c;
    bit poked = 0;
    logic [31:0] rx = '0;
    logic [31:0] mask;
    mask = (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
    @(negedge clk);
    ks_bit_i = k[0]; data_i = d; nbits_i = 6'(len); start_i = 1'b1; tick_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    while (cyc < 40000) begin
      c = carrier_o;
      if (cyc == 0) prev = c;
      else if (c != prev) begin
        if (prev == 1'b0) begin
          nlow++;
          if (run != GAP_T) badlow++;
        end else begin
          if (run == HI_ONE)      begin if (nhigh < 32) rx[nhigh] = 1'b1; end
          else if (run == HI_ZER) begin if (nhigh < 32) rx[nhigh] = 1'b0; end
          else badhigh++;
          nhigh++;
        end
        run = 0;
        prev = c;
      end
      if (done_o) begin ndone++; break; end
      if (ks_adv_o) begin
        adv++;
        ks_bit_i = (adv < 32) ? k[adv] : 1'b0;
      end
      start_i = 1'b0;
      if (poke && !poked && nhigh == 1 && c) begin
        poked = 1; start_i = 1'b1; data_i = ~d; nbits_i = 6'd5;
      end
      tick_i = ((cyc % gap) == 0);
      if (tick_i) run++;
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(ndone == 1, "R6", "done seen", ndone, 1);
    chk(badlow == 0, "R2", "pauses off-length", badlow, 0);
    chk(nlow == len + 1, "R6", "pause count incl. closing gap", nlow, len + 1);
    chk(badhigh == 0, "R4", "carrier-on spans off-length", badhigh, 0);
    chk(rx == ((d ^ k) & mask), "R3", "decoded word", rx, (d ^ k) & mask);
    chk(adv == len, "R5", "advance pulses", adv, len);
    if (poke) chk(poked, "R8", "busy start injected", poked, 1);
    @(negedge clk);
    chk(done_o == 1'b0 && carrier_o == 1'b1, "R6", "done one cycle, carrier on",
        {done_o, carrier_o}, 2'b01);
  endtask

  task automatic idle_watch(input int len);
    int bad = 0;
    @(negedge clk);
    nbits_i = 6'(len); data_i = 32'hFFFF_FFFF; start_i = 1'b1; tick_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (200) begin
      if (!carrier_o || done_o || ks_adv_o) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7", "illegal length ignored", bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(carrier_o == 1'b1 && ks_adv_o == 1'b0 && done_o == 1'b0, "R1", "outputs in reset",
        {carrier_o, ks_adv_o, done_o}, 3'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(carrier_o == 1'b1 && ks_adv_o == 1'b0 && done_o == 1'b0, "R1", "idle after reset",
        {carrier_o, ks_adv_o, done_o}, 3'b100);

    // Table walk: R2 R3 R4 R5 R6, with R9 on the gapped-tick rows
    for (int v = 0; v < NV; v++) begin
      run_frame(VDATA[v], VKEY[v], VLEN[v], VGAP[v], 1'b0);
      repeat (5) @(negedge clk);
    end

    // R7: zero and over-range counts
    idle_watch(0);
    idle_watch(33);

    // R8: start pulse in the middle of a frame
    run_frame(32'h0000_0A5C, 32'h0000_0003, 12, 1, 1'b1);
    repeat (20) @(negedge clk);
    chk(carrier_o == 1'b1 && done_o == 1'b0, "R8", "no second frame after busy start",
        {carrier_o, done_o}, 2'b10);

    // R10: back-to-back frames, first pause of the second must be full
    run_frame(32'h0000_0006, 32'h0, 3, 1, 1'b0);
    run_frame(32'h0000_0009, 32'h0000_0004, 4, 2, 1'b0);

    // R9: sparse ticks stretch time but not the tick count
    run_frame(32'h0000_0002, 32'h0, 2, 5, 1'b0);

    repeat (5) @(negedge clk);
    chk(carrier_o == 1'b1, "R1", "idle at end", carrier_o, 1);
    summary();
    $finish;
  end

endmodule